// File: doc/BRIEF.md
# Three-Level Symbol Remote Decoder

This block is the receiving half of a remote-control link whose symbols can be one, zero or open. It watches a serial line, one chip per clock. It finds word boundaries by looking for a run of low chips, then cuts the word into 18 three-chip symbols: 10 address symbols followed by 8 data symbols. It checks each address symbol against the symbol its own address pins stand for. It accepts data symbols only of the kinds the data mode allows.

A word counts as good only when it is well formed, its address matches and its data symbols are of an allowed type. When two good words in a row carry the same data, the decoder latches the data onto its outputs and raises the valid flag. Further identical good words keep the flag up. If no such refresh arrives within two minimum word periods, the flag drops and the data outputs hold their last value.

The address pins go through a two-pin mode table that gives each pin level a symbol meaning. The encoder uses the same table, so both ends must be strapped alike.

Top module: `tri_remote_decoder`

## Requirements
- R1: A symbol is three chips. The first chip is always high, and the last two give the kind: high,low = one; low,low = zero; low,high = open; high,high = malformed. A malformed symbol makes the whole word bad.
- R2: A word starts only at a high chip that follows at least SYNC_LEN (default 4) low chips. A high chip after a shorter low run, or a low first chip inside a word, is a sync violation. A sync violation drops the word being received and clears the consecutive-match count.
- R3: Address symbol i is symbol number i in the word, sent first. It must equal the local symbol of addrPins[i] under {addrModeHi,addrModeLo}. The mapping from pin high / pin low is: 00 gives one/zero; 01 gives one/open; 10 gives open/zero; 11 gives one/zero. Any mismatch makes the word bad.
- R4: Data symbols are symbols 10..17, carrying dataOut[0..7]. With dataMode high only one and zero are allowed. With dataMode low only one and open are allowed. A disallowed kind makes the word bad.
- R5: On the edge that samples the last chip of a good word whose data equals the data of the immediately preceding word, and that preceding word was also good, dataOut takes the new data and vtOut is 1. A data bit is 1 for a one symbol and 0 otherwise.
- R6: A good word whose data differs from the previous good word restarts the pairing, so only a following identical word latches.
- R7: A bad word clears the consecutive-match count. A good word that follows it does not latch on its own.
- R8: vtOut falls exactly TIMEOUT = 2*(SYNC_LEN+54) cycles after the last latching edge if no latch occurs in between. dataOut changes only on a latching edge.
- R9: After synchronous reset, vtOut is 0 and dataOut is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one chip per cycle |
| rst | input | 1 | Synchronous active-high reset |
| rxLine | input | 1 | Serial chip stream |
| addrPins | input | 10 | Local address levels |
| dataMode | input | 1 | 1: data symbols one/zero, 0: one/open |
| addrModeHi | input | 1 | Address interpretation select, upper bit |
| addrModeLo | input | 1 | Address interpretation select, lower bit |
| dataOut | output | 8 | Latched data |
| vtOut | output | 1 | Valid transmission flag |

## Verification
The hardest state to reach from the ports is a sync violation that lands between two otherwise good words. A word preceded by a short low run has to be ignored, and the count it clears has to stop the next good word from latching. The stimulus sends identical words separated by three low chips instead of four, and it sends a word with a malformed symbol between two matching ones. The timeout boundary is reached by letting the line idle low for exactly TIMEOUT-1 and then TIMEOUT cycles after a latch.

// File: rtl/trd_pkg.sv
package trd_pkg;
  typedef enum logic [1:0] {
    SYM_ZERO = 2'b00,
    SYM_OPEN = 2'b01,
    SYM_ONE  = 2'b10,
    SYM_BAD  = 2'b11
  } sym_e;

  typedef enum logic {ST_HUNT, ST_RECV} rx_state_e;

  typedef struct packed {
    logic       wordStart;
    logic       symDone;
    logic       lastSym;
    logic       syncErr;
    logic [1:0] tail;
  } rx_strobe_t;

  function automatic sym_e localCode(input logic pin, input logic [1:0] mode);
    case (mode)
      2'b01:   return pin ? SYM_ONE  : SYM_OPEN;
      2'b10:   return pin ? SYM_OPEN : SYM_ZERO;
      default: return pin ? SYM_ONE  : SYM_ZERO;
    endcase
  endfunction
endpackage

// File: rtl/trd_ctrl.sv
module trd_ctrl
  import trd_pkg::*;
#(
  parameter int SYNC_LEN = 4,
  parameter int NUM_SYM  = 18,
  localparam int IW = $clog2(NUM_SYM),
  localparam int RW = $clog2(SYNC_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rxLine,
  output rx_strobe_t    strb,
  output logic [IW-1:0] symIdx
);
  rx_state_e     state;
  logic [RW-1:0] lowRun;
  logic [1:0]    chipIdx;
  logic          midChip;

  always_comb begin
    strb = '0;
    strb.tail = {midChip, rxLine};
    strb.lastSym = (symIdx == IW'(NUM_SYM - 1));
    if (state == ST_HUNT) begin
      if (rxLine) begin
        if (lowRun >= RW'(SYNC_LEN)) strb.wordStart = 1'b1;
        else                         strb.syncErr   = 1'b1;
      end
    end else begin
      if (chipIdx == 2'd0 && !rxLine) strb.syncErr = 1'b1;
      if (chipIdx == 2'd2)            strb.symDone = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_HUNT;
      lowRun  <= '0;
      chipIdx <= '0;
      symIdx  <= '0;
      midChip <= 1'b0;
    end else if (state == ST_HUNT) begin
      if (!rxLine) begin
        if (lowRun != RW'(SYNC_LEN)) lowRun <= lowRun + 1'b1;
      end else begin
        lowRun <= '0;
        if (strb.wordStart) begin
          state   <= ST_RECV;
          symIdx  <= '0;
          chipIdx <= 2'd1;
        end
      end
    end else begin
      case (chipIdx)
        2'd0: begin
          if (!rxLine) begin
            state  <= ST_HUNT;
            lowRun <= RW'(1);
          end else chipIdx <= 2'd1;
        end
        2'd1: begin
          midChip <= rxLine;
          chipIdx <= 2'd2;
        end
        default: begin
          chipIdx <= 2'd0;
          if (strb.lastSym) begin
            state  <= ST_HUNT;
            lowRun <= '0;
          end else symIdx <= symIdx + 1'b1;
        end
      endcase
    end
  end

  p_recv_bounds_r1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RECV) |-> (chipIdx != 2'd3 && symIdx < IW'(NUM_SYM)));

  p_start_enters_recv_r2: assert property (@(posedge clk) disable iff (rst)
    strb.wordStart |=> (state == ST_RECV && chipIdx == 2'd1 && symIdx == '0));
endmodule

// File: rtl/trd_datapath.sv
module trd_datapath
  import trd_pkg::*;
#(
  parameter int ADDR_BITS = 10,
  parameter int DATA_BITS = 8,
  parameter int TIMEOUT   = 116,
  localparam int NUM_SYM = ADDR_BITS + DATA_BITS,
  localparam int IW      = $clog2(NUM_SYM),
  localparam int TW      = $clog2(TIMEOUT)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  rx_strobe_t           strb,
  input  logic [IW-1:0]        symIdx,
  input  logic [ADDR_BITS-1:0] addrPins,
  input  logic                 dataMode,
  input  logic [1:0]           addrMode,
  output logic [DATA_BITS-1:0] dataOut,
  output logic                 vt
);
  logic [2*NUM_SYM-1:0] expectVec;
  logic                 wordOk;
  logic [NUM_SYM-1:0]   wordBits, nextBits;
  logic [1:0]           matchCnt;
  logic [DATA_BITS-1:0] prevData, newData;
  logic [TW-1:0]        idleCnt;
  sym_e                 sym, expected;
  logic                 symOk, nextOk, sameAsPrev, latchNow;

  for (genvar i = 0; i < NUM_SYM; i++) begin : g_expect
    if (i < ADDR_BITS) begin : g_addr
      assign expectVec[2*i +: 2] = localCode(addrPins[i], addrMode);
    end else begin : g_data
      assign expectVec[2*i +: 2] = SYM_BAD;
    end
  end

  always_comb begin
    sym      = sym_e'(strb.tail);
    expected = sym_e'(expectVec[2*symIdx +: 2]);
    if (symIdx < IW'(ADDR_BITS)) symOk = (sym == expected);
    else if (dataMode)           symOk = (sym == SYM_ONE) || (sym == SYM_ZERO);
    else                         symOk = (sym == SYM_ONE) || (sym == SYM_OPEN);
    nextOk           = wordOk && symOk;
    nextBits         = wordBits;
    nextBits[symIdx] = (sym == SYM_ONE);
    newData          = nextBits[NUM_SYM-1 -: DATA_BITS];
    sameAsPrev       = (matchCnt != 2'd0) && (newData == prevData);
    latchNow         = strb.symDone && strb.lastSym && nextOk && sameAsPrev;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wordOk   <= 1'b0;
      wordBits <= '0;
      matchCnt <= '0;
      prevData <= '0;
    end else begin
      if (strb.syncErr) begin
        wordOk   <= 1'b0;
        matchCnt <= '0;
      end
      if (strb.wordStart) wordOk <= 1'b1;
      if (strb.symDone) begin
        wordOk   <= nextOk;
        wordBits <= nextBits;
        if (strb.lastSym) begin
          if (nextOk) begin
            matchCnt <= sameAsPrev ? 2'd2 : 2'd1;
            prevData <= newData;
          end else matchCnt <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dataOut <= '0;
      vt      <= 1'b0;
      idleCnt <= '0;
    end else if (latchNow) begin
      dataOut <= newData;
      vt      <= 1'b1;
      idleCnt <= '0;
    end else if (vt) begin
      if (idleCnt == TW'(TIMEOUT - 1)) vt <= 1'b0;
      else                             idleCnt <= idleCnt + 1'b1;
    end
  end

  p_cnt_range_r5: assert property (@(posedge clk) disable iff (rst)
    matchCnt <= 2'd2);

  p_rise_at_word_end_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(vt) |-> $past(strb.symDone && strb.lastSym));

  p_data_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(dataOut) |-> vt);

  p_sync_err_clears_r2: assert property (@(posedge clk) disable iff (rst)
    strb.syncErr |=> (matchCnt == 2'd0));
endmodule

// File: rtl/tri_remote_decoder.sv
module tri_remote_decoder
  import trd_pkg::*;
#(
  parameter int SYNC_LEN      = 4,
  parameter int ADDR_BITS     = 10,
  parameter int DATA_BITS     = 8,
  parameter int TIMEOUT_WORDS = 2,
  localparam int NUM_SYM    = ADDR_BITS + DATA_BITS,
  localparam int WORD_CHIPS = SYNC_LEN + 3 * NUM_SYM,
  localparam int TIMEOUT    = TIMEOUT_WORDS * WORD_CHIPS,
  localparam int IW         = $clog2(NUM_SYM)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rxLine,
  input  logic [ADDR_BITS-1:0] addrPins,
  input  logic                 dataMode,
  input  logic                 addrModeHi,
  input  logic                 addrModeLo,
  output logic [DATA_BITS-1:0] dataOut,
  output logic                 vtOut
);
  rx_strobe_t    strb;
  logic [IW-1:0] symIdx;

  trd_ctrl #(.SYNC_LEN(SYNC_LEN), .NUM_SYM(NUM_SYM)) u_ctrl (
    .clk(clk), .rst(rst), .rxLine(rxLine), .strb(strb), .symIdx(symIdx)
  );

  trd_datapath #(.ADDR_BITS(ADDR_BITS), .DATA_BITS(DATA_BITS), .TIMEOUT(TIMEOUT)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .symIdx(symIdx), .addrPins(addrPins),
    .dataMode(dataMode), .addrMode({addrModeHi, addrModeLo}),
    .dataOut(dataOut), .vt(vtOut)
  );
endmodule

// File: tb/tb_tri_remote_decoder.sv
module tb_tri_remote_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC_LEN   = 4;
  localparam int TIMEOUT    = 2 * (SYNC_LEN + 54);
  localparam logic [1:0] ONE = 2'b10, ZERO = 2'b00, OPEN = 2'b01, BAD = 2'b11;

  logic clk = 0, rst = 1, rxLine = 0;
  logic [9:0] addrPins = 10'h2A5;
  logic dataMode = 1, addrModeHi = 0, addrModeLo = 0;
  logic [7:0] dataOut;
  logic vtOut;

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference state
  bit expVt = 0;
  logic [7:0] expData = 0, prevWord = 0;
  int runCnt = 0, idle = 0;

  tri_remote_decoder dut (
    .clk(clk), .rst(rst), .rxLine(rxLine), .addrPins(addrPins), .dataMode(dataMode),
    .addrModeHi(addrModeHi), .addrModeLo(addrModeLo), .dataOut(dataOut), .vtOut(vtOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one edge of the reference model
  task automatic modelEdge(input bit wordEvt, input bit ok, input logic [7:0] d);
    bit reloaded = 0;
    if (wordEvt) begin
      if (ok) begin
        if (runCnt > 0 && d == prevWord) runCnt = 2; else runCnt = 1;
        prevWord = d;
        if (runCnt == 2) begin expData = d; expVt = 1; idle = 0; reloaded = 1; end
      end else runCnt = 0;
    end
    if (!reloaded && expVt) begin
      if (idle == TIMEOUT - 1) expVt = 0; else idle++;
    end
  endtask

  task automatic chip(input bit b, input bit wordEvt = 0, input bit ok = 0, input logic [7:0] d = 0);
    @(negedge clk);
    check("R5 vtOut per cycle", {7'b0, vtOut}, {7'b0, expVt});
    check("R5 dataOut per cycle", dataOut, expData);
    rxLine = b;
    modelEdge(wordEvt, ok, d);
  endtask

  function automatic logic [1:0] localSym(input bit pin, input logic [1:0] m);
    if (m == 2'b01) return pin ? ONE : OPEN;
    if (m == 2'b10) return pin ? OPEN : ZERO;
    return pin ? ONE : ZERO;
  endfunction

  task automatic sendWord(input logic [7:0] d, input int syncLen, input int badIdx,
                          input logic [1:0] badSym, input bit expectOk);
    logic [1:0] syms [18];
    for (int i = 0; i < 10; i++) syms[i] = localSym(addrPins[i], {addrModeHi, addrModeLo});
    for (int i = 0; i < 8; i++) syms[10+i] = d[i] ? ONE : (dataMode ? ZERO : OPEN);
    if (badIdx >= 0) syms[badIdx] = badSym;
    for (int i = 0; i < syncLen; i++) chip(0);
    for (int s = 0; s < 18; s++) begin
      chip(1);
      chip(syms[s][1]);
      chip(syms[s][0], s == 17, expectOk && syncLen >= SYNC_LEN, d);
    end
  endtask

  task automatic idleChips(input int n);
    for (int i = 0; i < n; i++) chip(0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    // R9 reset state
    check("R9 vtOut after reset", {7'b0, vtOut}, 8'd0);
    check("R9 dataOut after reset", dataOut, 8'd0);

    // R5 basic pair under one/zero data
    sendWord(8'hA5, 4, -1, 0, 1);
    check("R5 no latch after single word", {7'b0, vtOut}, 8'd0);
    sendWord(8'hA5, 4, -1, 0, 1);
    idleChips(1);
    check("R5 vt after pair", {7'b0, vtOut}, 8'd1);
    check("R5 data after pair", dataOut, 8'hA5);

    // R6 differing data restarts pairing
    sendWord(8'h3C, 4, -1, 0, 1);
    sendWord(8'h5A, 4, -1, 0, 1);
    idleChips(1);
    check("R6 no latch on differing words", dataOut, 8'hA5);
    sendWord(8'h5A, 4, -1, 0, 1);
    idleChips(1);
    check("R6 latch on repeat", dataOut, 8'h5A);

    // R7 and R1: malformed symbol between good words
    sendWord(8'h77, 4, -1, 0, 1);
    sendWord(8'h77, 4, 4, BAD, 0);
    sendWord(8'h77, 4, -1, 0, 1);
    idleChips(1);
    check("R7 R1 malformed word breaks pair", dataOut, 8'h5A);
    sendWord(8'h77, 4, -1, 0, 1);
    idleChips(1);
    check("R7 latch after recovery", dataOut, 8'h77);

    // R2 short sync is a violation, long sync accepted
    sendWord(8'h11, 4, -1, 0, 1);
    sendWord(8'h11, 3, -1, 0, 1);
    sendWord(8'h11, 4, -1, 0, 1);
    idleChips(1);
    check("R2 short sync breaks pair", dataOut, 8'h77);
    sendWord(8'h11, 9, -1, 0, 1);
    idleChips(1);
    check("R2 long sync accepted", dataOut, 8'h11);

    // R3 address mismatch and each address mode
    sendWord(8'h42, 4, 0, OPEN, 0);
    sendWord(8'h42, 4, 0, OPEN, 0);
    idleChips(1);
    check("R3 mismatched address ignored", dataOut, 8'h11);
    for (int m = 0; m < 4; m++) begin
      {addrModeHi, addrModeLo} = 2'(m);
      sendWord(8'h80 + 8'(m), 4, -1, 0, 1);
      sendWord(8'h80 + 8'(m), 4, -1, 0, 1);
      idleChips(1);
      check("R3 address mode latch", dataOut, 8'h80 + 8'(m));
    end
    addrModeHi = 0; addrModeLo = 1;
    sendWord(8'h24, 4, 1, ZERO, 0);
    sendWord(8'h24, 4, 1, ZERO, 0);
    idleChips(1);
    check("R3 zero where open expected", dataOut, 8'h83);

    // R4 data mode rules
    dataMode = 0;
    sendWord(8'hC3, 4, -1, 0, 1);
    sendWord(8'hC3, 4, -1, 0, 1);
    idleChips(1);
    check("R4 open data reads low", dataOut, 8'hC3);
    sendWord(8'h0F, 4, 12, ZERO, 0);
    sendWord(8'h0F, 4, 12, ZERO, 0);
    idleChips(1);
    check("R4 zero rejected in one/open mode", dataOut, 8'hC3);
    dataMode = 1;
    sendWord(8'hF0, 4, 11, OPEN, 0);
    sendWord(8'hF0, 4, 11, OPEN, 0);
    idleChips(1);
    check("R4 open rejected in one/zero mode", dataOut, 8'hC3);

    // R8 timeout boundary
    sendWord(8'h99, 4, -1, 0, 1);
    sendWord(8'h99, 4, -1, 0, 1);
    idleChips(TIMEOUT - 1);
    idleChips(1);
    check("R8 vt held until timeout", {7'b0, vtOut}, 8'd1);
    idleChips(1);
    check("R8 vt falls at timeout", {7'b0, vtOut}, 8'd0);
    check("R8 data held after vt falls", dataOut, 8'h99);
    idleChips(5);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule